// File: doc/BRIEF.md
# 32-to-16 Bit Peripheral Bridge

This block joins a fast host register port, 32 bits wide, to a slow 16-bit local bus. That bus serves a serial avionics transmitter and two receive channels. A host store of one transmit word becomes two timed 16-bit write strobes on the local bus. A status flag tells the host when the next word may be stored. The host never waits on the slow bus.

On the receive side, each channel raises a data-available line. The bridge fetches the word by itself with two 16-bit read strobes, assembles the 32-bit result and holds it. Only then does it flag the word as ready, so the host collects it in a single access. One sequencer owns the local bus and serves both receive channels and the transmit path, one transaction at a time.

Host address map: 0 status (read), 1 transmit data (write), 2 strobe length (read/write), 3 + c receive data of channel c (read). Status bits: bit 0 transmit ready, bit 1 transmit overrun, bit 2+2c channel c data ready, bit 3+2c channel c overrun.

Top module: `wide_narrow_bridge`

## Requirements
- R1: After reset all local-bus strobes are high, status reads 0x01 (transmit ready only) and the strobe-length register reads 2.
- R2: A host write to address 1 while ready produces exactly two write strobes: the first with dev_hi_o=0 carrying bits 15:0, the second with dev_hi_o=1 carrying bits 31:16.
- R3: Every local-bus strobe stays low for N clocks, where N is the strobe-length register value (bits 3:0). A value of 0 is treated as 1. The two halves of one transaction are separated by exactly one clock with all strobes high.
- R4: Status bit 0 (ready) drops in the cycle after an accepted transmit write. It stays low until the second write strobe has ended, then returns high.
- R5: A transmit write while ready is low is ignored, so no extra strobes appear and the first word is sent unchanged. It sets status bit 1, which stays set until the next status read.
- R6: When dev_avail_i[c] is high, the bridge issues two read strobes on dev_rd_no[c], low half first (dev_hi_o=0). It samples dev_rdata_i in the last low cycle of each strobe and then sets status bit 2+2c.
- R7: A read of address 3+c returns the assembled word {high half, low half} in the same cycle and clears status bit 2+2c.
- R8: A word fetched on channel c while bit 2+2c is still set is discarded, so the held word is kept. Status bit 3+2c is set and is cleared by the next status read.
- R9: When both channels request service in the same idle cycle, channel 0 is fetched first.
- R10: Reading one channel's data leaves the other channel's held word and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hst_wr_i | input | 1 | Host write strobe, one cycle |
| hst_rd_i | input | 1 | Host read strobe, one cycle |
| hst_addr_i | input | 3 | Host register address |
| hst_wdata_i | input | 32 | Host write data |
| hst_rdata_o | output | 32 | Host read data, combinational |
| dev_wr_no | output | 1 | Local-bus write strobe, active low |
| dev_rd_no | output | 2 | Per-channel local-bus read strobe, active low |
| dev_hi_o | output | 1 | Half select: 0 low half, 1 high half |
| dev_wdata_o | output | 16 | Local-bus write data |
| dev_rdata_i | input | 16 | Local-bus read data |
| dev_avail_i | input | 2 | Per-channel data-available request |

## Verification
The hardest case to reach is a receive overrun. It needs a word that is held and unread while the same channel presents a second word. The bench device model holds an unread word on channel 1, then loads a new word and raises the request again, and checks that the first word survives. The channel priority check raises both requests in the same cycle while the bus is idle, and then checks the order of the read strobes recorded by a bus monitor.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_STB  = 2'd1,
    S_GAP  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/lb_sequencer.sv
module lb_sequencer import bridge_pkg::*; #(
  parameter int HW    = 16,
  parameter int NCH   = 2,
  parameter int CNT_W = 4,
  localparam int DW   = 2 * HW,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCH-1:0]   req_rx_i,
  input  logic             req_tx_i,
  input  logic [DW-1:0]    tx_word_i,
  input  logic [CNT_W-1:0] stb_len_i,
  input  logic [HW-1:0]    dev_rdata_i,
  output logic             dev_wr_no,
  output logic [NCH-1:0]   dev_rd_no,
  output logic             dev_hi_o,
  output logic [HW-1:0]    dev_wdata_o,
  output logic [DW-1:0]    rx_word_o,
  output logic [NCH-1:0]   rx_done_o,
  output logic             tx_done_o
);
  seq_state_e       state_q;
  logic             op_tx_q, half_q;
  logic [CH_W-1:0]  op_ch_q, pick_ch;
  logic [CNT_W-1:0] cnt_q, len_q, eff_len;
  logic [DW-1:0]    word_q;
  logic             strobing, fin;

  assign eff_len  = (stb_len_i == '0) ? CNT_W'(1) : stb_len_i;
  assign strobing = (state_q == S_STB);
  assign fin      = (state_q == S_GAP) && half_q;

  // lowest index wins
  always_comb begin
    pick_ch = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (req_rx_i[i]) pick_ch = CH_W'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_tx_q <= 1'b0;
      op_ch_q <= '0;
      half_q  <= 1'b0;
      cnt_q   <= '0;
      len_q   <= CNT_W'(1);
      word_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          half_q <= 1'b0;
          cnt_q  <= '0;
          len_q  <= eff_len;
          if (|req_rx_i) begin
            op_tx_q <= 1'b0;
            op_ch_q <= pick_ch;
            state_q <= S_STB;
          end else if (req_tx_i) begin
            op_tx_q <= 1'b1;
            state_q <= S_STB;
          end
        end
        S_STB: begin
          if (cnt_q == len_q - CNT_W'(1)) begin
            if (!op_tx_q) begin
              if (half_q) word_q[DW-1:HW] <= dev_rdata_i;
              else        word_q[HW-1:0]  <= dev_rdata_i;
            end
            state_q <= S_GAP;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        S_GAP: begin
          cnt_q <= '0;
          if (half_q) begin
            state_q <= S_IDLE;
          end else begin
            half_q  <= 1'b1;
            state_q <= S_STB;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign dev_wr_no   = !(strobing && op_tx_q);
  assign dev_hi_o    = half_q;
  assign dev_wdata_o = half_q ? tx_word_i[DW-1:HW] : tx_word_i[HW-1:0];
  assign rx_word_o   = word_q;
  assign tx_done_o   = fin && op_tx_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign dev_rd_no[c] = !(strobing && !op_tx_q && (op_ch_q == CH_W'(c)));
    assign rx_done_o[c] = fin && !op_tx_q && (op_ch_q == CH_W'(c));
  end

  // R3
  half_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(strobing) && !strobing && !dev_hi_o) |=> (strobing && dev_hi_o));
  // R2
  half_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobing && $past(strobing)) |-> $stable(dev_hi_o));
  // R9
  ch0_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && req_rx_i[0]) |=> !dev_rd_no[0]);
  // R3
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({~dev_rd_no, ~dev_wr_no}));
endmodule

// File: rtl/tx_slot.sv
module tx_slot #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          done_i,
  input  logic          clr_i,
  output logic          pend_o,
  output logic          ovr_o,
  output logic [DW-1:0] data_o
);
  logic          pend_q, ovr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
      data_q <= '0;
    end else begin
      if (wr_i && !pend_q) begin
        data_q <= wdata_i;
        pend_q <= 1'b1;
      end else if (done_i) begin
        pend_q <= 1'b0;
      end
      if (wr_i && pend_q) ovr_q <= 1'b1;
      else if (clr_i)     ovr_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign ovr_o  = ovr_q;
  assign data_o = data_q;

  // R5
  tx_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && pend_q) |=> ($stable(data_q) && ovr_q));
  // R4
  tx_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !pend_q) |=> pend_q);
endmodule

// File: rtl/rx_slot.sv
module rx_slot #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic [DW-1:0] word_i,
  input  logic          rd_i,
  input  logic          clr_i,
  output logic          rdy_o,
  output logic          ovr_o,
  output logic [DW-1:0] data_o
);
  logic          rdy_q, ovr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q  <= 1'b0;
      ovr_q  <= 1'b0;
      data_q <= '0;
    end else begin
      // a read in the same cycle frees the slot for the new word
      if (done_i && (!rdy_q || rd_i)) begin
        data_q <= word_i;
        rdy_q  <= 1'b1;
      end else if (rd_i) begin
        rdy_q <= 1'b0;
      end
      if (done_i && rdy_q && !rd_i) ovr_q <= 1'b1;
      else if (clr_i)               ovr_q <= 1'b0;
    end
  end

  assign rdy_o  = rdy_q;
  assign ovr_o  = ovr_q;
  assign data_o = data_q;

  // R8
  rx_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && rdy_q && !rd_i) |=> ($stable(data_q) && ovr_q));
  // R7
  rx_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !done_i) |=> !rdy_q);
endmodule

// File: rtl/wide_narrow_bridge.sv
module wide_narrow_bridge #(
  parameter int HW      = 16,
  parameter int NCH     = 2,
  parameter int CNT_W   = 4,
  parameter int ADDR_W  = 3,
  parameter int STB_RST = 2,
  localparam int DW     = 2 * HW,
  localparam int RX_BASE = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hst_wr_i,
  input  logic              hst_rd_i,
  input  logic [ADDR_W-1:0] hst_addr_i,
  input  logic [DW-1:0]     hst_wdata_i,
  output logic [DW-1:0]     hst_rdata_o,
  output logic              dev_wr_no,
  output logic [NCH-1:0]    dev_rd_no,
  output logic              dev_hi_o,
  output logic [HW-1:0]     dev_wdata_o,
  input  logic [HW-1:0]     dev_rdata_i,
  input  logic [NCH-1:0]    dev_avail_i
);
  localparam int STAT_W = 2 + 2 * NCH;

  logic             stat_rd, tx_wr, cfg_wr;
  logic             tx_pend, tx_ovr, tx_done;
  logic [DW-1:0]    tx_data, rx_word;
  logic [CNT_W-1:0] cfg_q;
  logic [NCH-1:0]   rx_done, rx_rd, rx_rdy, rx_ovr;
  logic [DW-1:0]    rx_data [NCH];
  logic [STAT_W-1:0] stat;

  assign stat_rd = hst_rd_i && (hst_addr_i == ADDR_W'(0));
  assign tx_wr   = hst_wr_i && (hst_addr_i == ADDR_W'(1));
  assign cfg_wr  = hst_wr_i && (hst_addr_i == ADDR_W'(2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= CNT_W'(STB_RST);
    else if (cfg_wr) cfg_q <= hst_wdata_i[CNT_W-1:0];
  end

  tx_slot #(.DW(DW)) u_tx (
    .clk_i, .rst_ni,
    .wr_i(tx_wr), .wdata_i(hst_wdata_i), .done_i(tx_done), .clr_i(stat_rd),
    .pend_o(tx_pend), .ovr_o(tx_ovr), .data_o(tx_data)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_rx
    assign rx_rd[c] = hst_rd_i && (hst_addr_i == ADDR_W'(RX_BASE + c));
    rx_slot #(.DW(DW)) u_rx (
      .clk_i, .rst_ni,
      .done_i(rx_done[c]), .word_i(rx_word), .rd_i(rx_rd[c]), .clr_i(stat_rd),
      .rdy_o(rx_rdy[c]), .ovr_o(rx_ovr[c]), .data_o(rx_data[c])
    );
    assign stat[2+2*c] = rx_rdy[c];
    assign stat[3+2*c] = rx_ovr[c];
  end
  assign stat[0] = !tx_pend;
  assign stat[1] = tx_ovr;

  lb_sequencer #(.HW(HW), .NCH(NCH), .CNT_W(CNT_W)) u_seq (
    .clk_i, .rst_ni,
    .req_rx_i(dev_avail_i), .req_tx_i(tx_pend), .tx_word_i(tx_data),
    .stb_len_i(cfg_q), .dev_rdata_i,
    .dev_wr_no, .dev_rd_no, .dev_hi_o, .dev_wdata_o,
    .rx_word_o(rx_word), .rx_done_o(rx_done), .tx_done_o(tx_done)
  );

  always_comb begin
    hst_rdata_o = '0;
    if (hst_addr_i == ADDR_W'(0)) hst_rdata_o = DW'(stat);
    else if (hst_addr_i == ADDR_W'(2)) hst_rdata_o = DW'(cfg_q);
    for (int c = 0; c < NCH; c++)
      if (hst_addr_i == ADDR_W'(RX_BASE + c)) hst_rdata_o = rx_data[c];
  end

  // R1
  idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (dev_wr_no && (&dev_rd_no)));
  // R10
  rx_indep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rd[0] && !rx_done[1]) |=> $stable(rx_rdy[1]));
endmodule

// File: tb/tb_wide_narrow_bridge.sv
module tb_wide_narrow_bridge;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        hst_wr = 0, hst_rd = 0;
  logic [2:0]  hst_addr = '0;
  logic [31:0] hst_wdata = '0, hst_rdata;
  logic        dev_wr_n, dev_hi;
  logic [1:0]  dev_rd_n;
  logic [15:0] dev_wdata, dev_rdata;
  logic [1:0]  dev_avail = '0;
  logic [31:0] dev_word [2];

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  wide_narrow_bridge dut (
    .clk_i(clk), .rst_ni(rst_n),
    .hst_wr_i(hst_wr), .hst_rd_i(hst_rd), .hst_addr_i(hst_addr),
    .hst_wdata_i(hst_wdata), .hst_rdata_o(hst_rdata),
    .dev_wr_no(dev_wr_n), .dev_rd_no(dev_rd_n), .dev_hi_o(dev_hi),
    .dev_wdata_o(dev_wdata), .dev_rdata_i(dev_rdata), .dev_avail_i(dev_avail)
  );

  // device model
  assign dev_rdata = !dev_rd_n[0] ? (dev_hi ? dev_word[0][31:16] : dev_word[0][15:0]) :
                     !dev_rd_n[1] ? (dev_hi ? dev_word[1][31:16] : dev_word[1][15:0]) : 16'h0;
  always @(posedge clk)
    for (int c = 0; c < 2; c++)
      if (!dev_rd_n[c] && dev_hi) dev_avail[c] <= 1'b0;

  // bus monitor: kind 0 write, 1 read ch0, 2 read ch1
  int ev_n = 0;
  int ev_kind [32], ev_w [32], ev_gap [32];
  logic ev_hi [32];
  logic [15:0] ev_data [32];
  int run_kind = 3, cur_w = 0, cur_gap = 0, idle_run = 0;
  logic cur_hi;
  logic [15:0] cur_data;
  always @(negedge clk) if (rst_n) begin
    int k;
    k = !dev_wr_n ? 0 : !dev_rd_n[0] ? 1 : !dev_rd_n[1] ? 2 : 3;
    if (k != 3) begin
      if (run_kind == 3) begin cur_gap = idle_run; cur_w = 0; end
      cur_w++;
      cur_hi = dev_hi;
      cur_data = (k == 0) ? dev_wdata : dev_rdata;
      idle_run = 0;
    end else begin
      if (run_kind != 3 && ev_n < 32) begin
        ev_kind[ev_n] = run_kind; ev_w[ev_n] = cur_w; ev_gap[ev_n] = cur_gap;
        ev_hi[ev_n] = cur_hi; ev_data[ev_n] = cur_data; ev_n++;
      end
      idle_run++;
    end
    run_kind = k;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); hst_wr = 1; hst_addr = a; hst_wdata = d;
    @(negedge clk); hst_wr = 0;
  endtask

  task automatic hread(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); hst_rd = 1; hst_addr = a;
    #1 d = hst_rdata;
    @(negedge clk); hst_rd = 0;
  endtask

  task automatic settle();
    repeat (60) @(posedge clk);
  endtask

  task automatic clear_log();
    @(posedge clk); ev_n = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(dev_wr_n && (&dev_rd_n), "R1 strobes", {dev_wr_n, dev_rd_n}, 3'b111);
    hread(0, d); chk(d == 32'h1, "R1 status", d, 32'h1);
    hread(2, d); chk(d == 32'h2, "R1 length", d, 32'h2);
  endtask

  task automatic t_tx_basic();
    logic [31:0] d;
    clear_log();
    hwrite(1, 32'hA5A5_1234);
    hread(0, d); chk(d[0] == 1'b0, "R4 busy", d[0], 0);
    settle();
    chk(ev_n == 2, "R2 count", ev_n, 2);
    chk(ev_kind[0] == 0 && !ev_hi[0] && ev_data[0] == 16'h1234, "R2 low half", ev_data[0], 16'h1234);
    chk(ev_kind[1] == 0 && ev_hi[1] && ev_data[1] == 16'hA5A5, "R2 high half", ev_data[1], 16'hA5A5);
    chk(ev_w[0] == 2 && ev_w[1] == 2, "R3 width", ev_w[1], 2);
    chk(ev_gap[1] == 1, "R3 gap", ev_gap[1], 1);
    hread(0, d); chk(d[0] == 1'b1, "R4 ready again", d[0], 1);
  endtask

  task automatic t_widths();
    logic [31:0] d;
    hwrite(2, 32'h5);
    hread(2, d); chk(d == 32'h5, "R3 length reg", d, 5);
    clear_log(); hwrite(1, 32'h0F0F_F0F0); settle();
    chk(ev_n == 2 && ev_w[0] == 5 && ev_w[1] == 5, "R3 width 5", ev_w[0], 5);
    chk(ev_gap[1] == 1, "R3 gap 5", ev_gap[1], 1);
    hwrite(2, 32'h0);
    clear_log(); hwrite(1, 32'h1111_2222); settle();
    chk(ev_n == 2 && ev_w[0] == 1 && ev_w[1] == 1, "R3 width zero", ev_w[0], 1);
    hwrite(2, 32'h2);
  endtask

  task automatic t_tx_overrun();
    logic [31:0] d;
    clear_log();
    hwrite(1, 32'hCAFE_0001);
    hwrite(1, 32'hDEAD_0002);
    settle();
    chk(ev_n == 2, "R5 no extra strobes", ev_n, 2);
    chk(ev_data[0] == 16'h0001 && ev_data[1] == 16'hCAFE, "R5 first word kept", {ev_data[1], ev_data[0]}, 32'hCAFE_0001);
    hread(0, d); chk(d == 32'h3, "R5 overrun set", d, 32'h3);
    hread(0, d); chk(d == 32'h1, "R5 overrun cleared", d, 32'h1);
  endtask

  task automatic t_rx_single();
    logic [31:0] d;
    clear_log();
    @(negedge clk); dev_word[0] = 32'hDEAD_BEEF; dev_avail[0] = 1;
    settle();
    chk(ev_n == 2 && ev_kind[0] == 1 && ev_kind[1] == 1, "R6 two reads", ev_n, 2);
    chk(!ev_hi[0] && ev_hi[1], "R6 low first", {ev_hi[0], ev_hi[1]}, 2'b01);
    hread(0, d); chk(d == 32'h5, "R6 ready flag", d, 32'h5);
    hread(3, d); chk(d == 32'hDEAD_BEEF, "R7 data", d, 32'hDEAD_BEEF);
    hread(0, d); chk(d == 32'h1, "R7 flag cleared", d, 32'h1);
  endtask

  task automatic t_rx_overrun();
    logic [31:0] d;
    @(negedge clk); dev_word[1] = 32'h1357_9BDF; dev_avail[1] = 1;
    settle();
    @(negedge clk); dev_word[1] = 32'h2468_ACE0; dev_avail[1] = 1;
    settle();
    hread(0, d); chk(d == 32'h31, "R8 overrun set", d, 32'h31);
    hread(0, d); chk(d == 32'h11, "R8 overrun cleared", d, 32'h11);
    hread(4, d); chk(d == 32'h1357_9BDF, "R8 old word kept", d, 32'h1357_9BDF);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    clear_log();
    @(negedge clk);
    dev_word[0] = 32'hAAAA_5555; dev_word[1] = 32'h7777_8888; dev_avail = 2'b11;
    settle();
    chk(ev_n == 4 && ev_kind[0] == 1 && ev_kind[2] == 2, "R9 ch0 first", ev_kind[0], 1);
    hread(0, d); chk(d == 32'h15, "R9 both ready", d, 32'h15);
    hread(3, d); chk(d == 32'hAAAA_5555, "R10 ch0 data", d, 32'hAAAA_5555);
    hread(0, d); chk(d == 32'h11, "R10 ch1 untouched", d, 32'h11);
    hread(4, d); chk(d == 32'h7777_8888, "R10 ch1 data", d, 32'h7777_8888);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (2) @(posedge clk);
    t_reset();
    t_tx_basic();
    t_widths();
    t_tx_overrun();
    t_rx_single();
    t_rx_overrun();
    t_priority();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule